// File: doc/BRIEF.md
# Tagged Register-File Command Processor

This block serves four independent command ports that share sixteen 32-bit data registers. Each command names registers rather than carrying operands. Arithmetic and shift commands read two source registers and write a destination register. A store copies the port's data bus into a register, and a fetch returns a register's contents. Two conditional commands test register contents: one tests a register against zero, the other compares two registers for equality. When the test holds, the next command issued on the same port is cancelled.

Every port answers each command one clock later with a two-bit response code, a 32-bit data word and the tag that came with the command. A cancelled command changes nothing and answers with a code of its own. Each port runs a two-state machine. PORT_READY executes commands. PORT_SKIP cancels the next command that is not idle. The transition ARM_SKIP goes from PORT_READY to PORT_SKIP on a taken branch. The transition CONSUME_SKIP goes from PORT_SKIP back to PORT_READY on the first non-idle command. Idle cycles leave both states unchanged.

Top module: `tagged_reg_proc`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, every response, data and tag output is zero, every register reads as zero, and no port is armed to skip.
- R2: Store (command 5) writes the port's data input into the destination register. It answers response 01 with data 0.
- R3: Fetch (command 6) answers response 01 with the current value of the first source register and writes nothing.
- R4: Add (command 1) writes and returns the unsigned sum of the two source registers with response 01. A carry out of bit 31 answers response 10 with data 0 and leaves the destination unchanged.
- R5: Subtract (command 2) writes and returns source1 minus source2 with response 01. When source2 is greater than source1 (underflow), it answers response 10 with data 0 and writes nothing.
- R6: Shift left (command 3) and shift right (command 4) shift source1 by the amount held in bits 4:0 of source2, filling with zeros. They write and return the result with response 01.
- R7: Branch-if-zero (command 7) tests whether source1 is zero. Branch-if-equal (command 8) tests whether source1 equals source2. Either answers response 01, with data 1 when the test holds and data 0 when it does not, and writes nothing.
- R8: After a taken branch, the next non-idle command on the same port is cancelled. It answers response 11 with data 0, writes nothing, and does not evaluate a branch. Idle cycles between the two do not consume the cancellation, and other ports are unaffected.
- R9: When several ports write the same register in one cycle, the lowest-numbered port's value is kept. A read in that same cycle returns the old value.
- R10: Every non-idle command answers exactly one cycle later with its own tag and a non-zero response code. An idle command (0) yields response 00, data 0 and tag 0.
- R11: Command codes 9 to 15 answer response 10 with data 0 and change no register.
- R12: No two ports issue non-idle commands carrying the same tag in the same cycle. This is a condition on the environment, and it is monitored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_i | input | NPORTS x 4 | Command code per port, 0 = idle |
| dst_i | input | NPORTS x AW | Destination register per port |
| src1_i | input | NPORTS x AW | First source register per port |
| src2_i | input | NPORTS x AW | Second source register per port |
| data_i | input | NPORTS x DW | Store data per port |
| tag_i | input | NPORTS x TW | Command tag per port |
| resp_o | output | NPORTS x 2 | Response: 00 none, 01 ok, 10 error, 11 cancelled |
| data_o | output | NPORTS x DW | Result data per port |
| tag_o | output | NPORTS x TW | Echoed tag per port |

## Verification
Each result is due one clock after its command is presented. The bench drives a command on a falling edge and reads the outputs on the next falling edge, after exactly one rising edge has passed. Register writes become visible to commands presented in the following cycle. A cancellation armed by a branch is seen by the next non-idle command on that port, however many idle cycles come between. The bench's reference model advances one step per clock, and after each step it compares the response, data and tag of all four ports.

// File: rtl/trp_pkg.sv
package trp_pkg;

    localparam int CMD_W = 4;

    typedef enum logic [CMD_W-1:0] {
        OP_IDLE  = 4'd0,
        OP_ADD   = 4'd1,
        OP_SUB   = 4'd2,
        OP_SHL   = 4'd3,
        OP_SHR   = 4'd4,
        OP_STORE = 4'd5,
        OP_FETCH = 4'd6,
        OP_BRZ   = 4'd7,
        OP_BRE   = 4'd8
    } op_e;

    typedef enum logic [1:0] {
        RSP_NONE = 2'b00,
        RSP_OK   = 2'b01,
        RSP_ERR  = 2'b10,
        RSP_SKIP = 2'b11
    } rsp_e;

    typedef enum logic {
        PORT_READY = 1'b0,
        PORT_SKIP  = 1'b1
    } pstate_e;

endpackage

// File: rtl/trp_regbank.sv
module trp_regbank #(
    parameter int NPORTS = 4,
    parameter int NREGS  = 16,
    parameter int DW     = 32,
    parameter int AW     = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NPORTS-1:0]               we_i,
    input  logic [NPORTS-1:0][AW-1:0]       waddr_i,
    input  logic [NPORTS-1:0][DW-1:0]       wdata_i,
    input  logic [2*NPORTS-1:0][AW-1:0]     raddr_i,
    output logic [2*NPORTS-1:0][DW-1:0]     rdata_o
);

    localparam int NRD = 2 * NPORTS;

    logic [DW-1:0] regs_q [NREGS];

    // Highest port first, so the lowest-numbered port's assignment lands last.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++) begin
                regs_q[r] <= '0;
            end
        end else begin
            for (int p = NPORTS - 1; p >= 0; p--) begin
                if (we_i[p]) begin
                    regs_q[waddr_i[p]] <= wdata_i[p];
                end
            end
        end
    end

    for (genvar i = 0; i < NRD; i++) begin : g_rd
        assign rdata_o[i] = regs_q[raddr_i[i]];
    end

endmodule

// File: rtl/trp_port_exec.sv
module trp_port_exec
    import trp_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 4,
    parameter int TW = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CMD_W-1:0]    cmd_i,
    input  logic [AW-1:0]       dst_i,
    input  logic [DW-1:0]       data_i,
    input  logic [TW-1:0]       tag_i,
    input  logic [DW-1:0]       opa_i,
    input  logic [DW-1:0]       opb_i,
    output logic                we_o,
    output logic [AW-1:0]       waddr_o,
    output logic [DW-1:0]       wdata_o,
    output logic [1:0]          resp_o,
    output logic [DW-1:0]       dout_o,
    output logic [TW-1:0]       tag_o
);

    localparam int SHW = $clog2(DW);

    pstate_e        st_q, st_d;
    logic           active;
    logic           take;
    logic           we_c;
    rsp_e           rsp_c;
    logic [DW-1:0]  res_c;
    logic [DW:0]    sum_w;
    logic [SHW-1:0] shamt;

    assign active = (cmd_i != OP_IDLE);
    assign shamt  = opb_i[SHW-1:0];
    assign sum_w  = {1'b0, opa_i} + {1'b0, opb_i};

    // Command evaluation
    always_comb begin
        rsp_c = RSP_NONE;
        res_c = '0;
        we_c  = 1'b0;
        take  = 1'b0;
        if (active && st_q == PORT_SKIP) begin
            rsp_c = RSP_SKIP;
        end else if (active) begin
            case (op_e'(cmd_i))
                OP_ADD: begin
                    if (sum_w[DW]) begin
                        rsp_c = RSP_ERR;
                    end else begin
                        rsp_c = RSP_OK;
                        res_c = sum_w[DW-1:0];
                        we_c  = 1'b1;
                    end
                end
                OP_SUB: begin
                    if (opb_i > opa_i) begin
                        rsp_c = RSP_ERR;
                    end else begin
                        rsp_c = RSP_OK;
                        res_c = opa_i - opb_i;
                        we_c  = 1'b1;
                    end
                end
                OP_SHL: begin
                    rsp_c = RSP_OK;
                    res_c = opa_i << shamt;
                    we_c  = 1'b1;
                end
                OP_SHR: begin
                    rsp_c = RSP_OK;
                    res_c = opa_i >> shamt;
                    we_c  = 1'b1;
                end
                OP_STORE: begin
                    rsp_c = RSP_OK;
                    we_c  = 1'b1;
                end
                OP_FETCH: begin
                    rsp_c = RSP_OK;
                    res_c = opa_i;
                end
                OP_BRZ: begin
                    rsp_c = RSP_OK;
                    take  = (opa_i == '0);
                    res_c = DW'(take);
                end
                OP_BRE: begin
                    rsp_c = RSP_OK;
                    take  = (opa_i == opb_i);
                    res_c = DW'(take);
                end
                default: begin
                    rsp_c = RSP_ERR;
                end
            endcase
        end
    end

    assign we_o    = we_c;
    assign waddr_o = dst_i;
    assign wdata_o = (op_e'(cmd_i) == OP_STORE) ? data_i : res_c;

    // Next-state logic: ARM_SKIP and CONSUME_SKIP
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            PORT_READY: if (take)   st_d = PORT_SKIP;
            PORT_SKIP:  if (active) st_d = PORT_READY;
            default:                st_d = PORT_READY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= PORT_READY;
        end else begin
            st_q <= st_d;
        end
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            resp_o <= RSP_NONE;
            dout_o <= '0;
            tag_o  <= '0;
        end else begin
            resp_o <= rsp_c;
            dout_o <= (rsp_c == RSP_OK) ? res_c : '0;
            tag_o  <= active ? tag_i : '0;
        end
    end

endmodule

// File: rtl/tagged_reg_proc.sv
module tagged_reg_proc
    import trp_pkg::*;
#(
    parameter int NPORTS = 4,
    parameter int NREGS  = 16,
    parameter int DW     = 32,
    parameter int TW     = 2,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NPORTS-1:0][CMD_W-1:0]    cmd_i,
    input  logic [NPORTS-1:0][AW-1:0]       dst_i,
    input  logic [NPORTS-1:0][AW-1:0]       src1_i,
    input  logic [NPORTS-1:0][AW-1:0]       src2_i,
    input  logic [NPORTS-1:0][DW-1:0]       data_i,
    input  logic [NPORTS-1:0][TW-1:0]       tag_i,
    output logic [NPORTS-1:0][1:0]          resp_o,
    output logic [NPORTS-1:0][DW-1:0]       data_o,
    output logic [NPORTS-1:0][TW-1:0]       tag_o
);

    logic [NPORTS-1:0]               we_w;
    logic [NPORTS-1:0][AW-1:0]       waddr_w;
    logic [NPORTS-1:0][DW-1:0]       wdata_w;
    logic [2*NPORTS-1:0][AW-1:0]     raddr_w;
    logic [2*NPORTS-1:0][DW-1:0]     rdata_w;

    trp_regbank #(
        .NPORTS (NPORTS),
        .NREGS  (NREGS),
        .DW     (DW),
        .AW     (AW)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (we_w),
        .waddr_i (waddr_w),
        .wdata_i (wdata_w),
        .raddr_i (raddr_w),
        .rdata_o (rdata_w)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign raddr_w[2*p]   = src1_i[p];
        assign raddr_w[2*p+1] = src2_i[p];

        trp_port_exec #(
            .DW (DW),
            .AW (AW),
            .TW (TW)
        ) u_exec (
            .clk     (clk),
            .rst_n   (rst_n),
            .cmd_i   (cmd_i[p]),
            .dst_i   (dst_i[p]),
            .data_i  (data_i[p]),
            .tag_i   (tag_i[p]),
            .opa_i   (rdata_w[2*p]),
            .opb_i   (rdata_w[2*p+1]),
            .we_o    (we_w[p]),
            .waddr_o (waddr_w[p]),
            .wdata_o (wdata_w[p]),
            .resp_o  (resp_o[p]),
            .dout_o  (data_o[p]),
            .tag_o   (tag_o[p])
        );
    end

endmodule

// File: rtl/tagged_reg_proc_chk.sv
module tagged_reg_proc_chk #(
    parameter int NPORTS = 4,
    parameter int DW     = 32,
    parameter int TW     = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NPORTS-1:0][3:0]       cmd_i,
    input logic [NPORTS-1:0][TW-1:0]    tag_i,
    input logic [NPORTS-1:0][1:0]       resp_o,
    input logic [NPORTS-1:0][DW-1:0]    data_o,
    input logic [NPORTS-1:0][TW-1:0]    tag_o
);

    for (genvar p = 0; p < NPORTS; p++) begin : g_p
        // R10
        idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i[p] == 4'd0) |=> (resp_o[p] == 2'b00 && data_o[p] == '0 && tag_o[p] == '0));
        // R10
        tag_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i[p] != 4'd0) |=> (tag_o[p] == $past(tag_i[p]) && resp_o[p] != 2'b00));
        // R8
        skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (resp_o[p] == 2'b11) |-> (data_o[p] == '0));
        // R11
        err_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (resp_o[p] == 2'b10) |-> (data_o[p] == '0));
        // R7
        branch_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i[p] == 4'd7 || cmd_i[p] == 4'd8) |=> (data_o[p][DW-1:1] == '0));
        // R11
        bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_i[p] >= 4'd9) |=> (resp_o[p] == 2'b10 || resp_o[p] == 2'b11));
    end

    for (genvar a = 0; a < NPORTS; a++) begin : g_a
        for (genvar b = a + 1; b < NPORTS; b++) begin : g_b
            // R12
            tag_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd_i[a] != 4'd0 && cmd_i[b] != 4'd0) |-> (tag_i[a] != tag_i[b]));
        end
    end

endmodule

bind tagged_reg_proc tagged_reg_proc_chk #(
    .NPORTS (NPORTS),
    .DW     (DW),
    .TW     (TW)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_i  (cmd_i),
    .tag_i  (tag_i),
    .resp_o (resp_o),
    .data_o (data_o),
    .tag_o  (tag_o)
);

// File: tb/tb_tagged_reg_proc.sv
module tb_tagged_reg_proc;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int NR = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NP-1:0][3:0]  cmd_d  = '0;
    logic [NP-1:0][3:0]  dst_d  = '0;
    logic [NP-1:0][3:0]  s1_d   = '0;
    logic [NP-1:0][3:0]  s2_d   = '0;
    logic [NP-1:0][31:0] dat_d  = '0;
    logic [NP-1:0][1:0]  tag_d  = '0;
    logic [NP-1:0][1:0]  resp_w;
    logic [NP-1:0][31:0] data_w;
    logic [NP-1:0][1:0]  tago_w;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [31:0] mreg [NR];
    bit          mskip [NP];
    logic [1:0]  exp_rsp [NP];
    logic [31:0] exp_dat [NP];
    logic [1:0]  exp_tag [NP];
    string       exp_req [NP];

    always #(CLK_PERIOD/2) clk = ~clk;

    tagged_reg_proc dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd_i  (cmd_d),
        .dst_i  (dst_d),
        .src1_i (s1_d),
        .src2_i (s2_d),
        .data_i (dat_d),
        .tag_i  (tag_d),
        .resp_o (resp_w),
        .data_o (data_w),
        .tag_o  (tago_w)
    );

    task automatic chk(string req, logic [35:0] got, logic [35:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic model_step();
        logic [31:0] snap [NR];
        bit          wen [NP];
        for (int r = 0; r < NR; r++) snap[r] = mreg[r];
        for (int p = 0; p < NP; p++) begin
            logic [31:0] a;
            logic [31:0] b;
            logic [32:0] s;
            a = snap[s1_d[p]];
            b = snap[s2_d[p]];
            wen[p] = 0;
            exp_rsp[p] = 2'b00; exp_dat[p] = '0; exp_tag[p] = '0; exp_req[p] = "R10";
            if (cmd_d[p] != 0) begin
                exp_tag[p] = tag_d[p];
                if (mskip[p]) begin
                    exp_rsp[p] = 2'b11; exp_req[p] = "R8"; mskip[p] = 0;
                end else begin
                    case (cmd_d[p])
                        4'd1: begin
                            exp_req[p] = "R4";
                            s = {1'b0, a} + {1'b0, b};
                            if (s[32]) exp_rsp[p] = 2'b10;
                            else begin exp_rsp[p] = 2'b01; exp_dat[p] = s[31:0]; wen[p] = 1; end
                        end
                        4'd2: begin
                            exp_req[p] = "R5";
                            if (b > a) exp_rsp[p] = 2'b10;
                            else begin exp_rsp[p] = 2'b01; exp_dat[p] = a - b; wen[p] = 1; end
                        end
                        4'd3: begin exp_req[p] = "R6"; exp_rsp[p] = 2'b01; exp_dat[p] = a << b[4:0]; wen[p] = 1; end
                        4'd4: begin exp_req[p] = "R6"; exp_rsp[p] = 2'b01; exp_dat[p] = a >> b[4:0]; wen[p] = 1; end
                        4'd5: begin exp_req[p] = "R2"; exp_rsp[p] = 2'b01; wen[p] = 1; end
                        4'd6: begin exp_req[p] = "R3"; exp_rsp[p] = 2'b01; exp_dat[p] = a; end
                        4'd7: begin
                            exp_req[p] = "R7"; exp_rsp[p] = 2'b01;
                            exp_dat[p] = {31'd0, a == 0}; mskip[p] = (a == 0);
                        end
                        4'd8: begin
                            exp_req[p] = "R7"; exp_rsp[p] = 2'b01;
                            exp_dat[p] = {31'd0, a == b}; mskip[p] = (a == b);
                        end
                        default: begin exp_req[p] = "R11"; exp_rsp[p] = 2'b10; end
                    endcase
                end
            end
        end
        // R9: the lowest-numbered writer is applied last
        for (int p = NP - 1; p >= 0; p--) begin
            if (wen[p]) mreg[dst_d[p]] = (cmd_d[p] == 4'd5) ? dat_d[p] : exp_dat[p];
        end
    endtask

    task automatic step();
        model_step();
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk(exp_req[p], {resp_w[p], data_w[p], tago_w[p]},
                {exp_rsp[p], exp_dat[p], exp_tag[p]});
        end
    endtask

    task automatic idle_all();
        cmd_d = '0; dst_d = '0; s1_d = '0; s2_d = '0; dat_d = '0; tag_d = '0;
    endtask

    task automatic put(int p, logic [3:0] c, logic [3:0] d, logic [3:0] a,
                       logic [3:0] b, logic [31:0] v, logic [1:0] t);
        cmd_d[p] = c; dst_d[p] = d; s1_d[p] = a; s2_d[p] = b; dat_d[p] = v; tag_d[p] = t;
    endtask

    function automatic logic [31:0] pick_val();
        case ($urandom_range(0, 5))
            0: return 32'h0;
            1: return 32'h1;
            2: return 32'hFFFF_FFFF;
            3: return 32'h8000_0000;
            4: return {27'd0, 5'($urandom_range(0, 31))};
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd4711));
        for (int r = 0; r < NR; r++) mreg[r] = '0;
        for (int p = 0; p < NP; p++) mskip[p] = 0;

        // R1: outputs quiet during reset
        repeat (3) @(negedge clk);
        for (int p = 0; p < NP; p++) chk("R1", {resp_w[p], data_w[p], tago_w[p]}, '0);
        rst_n = 1'b1;
        step();
        // R1: registers read as zero after reset
        put(0, 4'd6, 0, 4'd5, 0, 0, 2'd0);
        put(1, 4'd6, 0, 4'd15, 0, 0, 2'd1);
        step();
        chk("R1", {resp_w[0], data_w[0], tago_w[0]}, {2'b01, 32'h0, 2'd0});

        // R2: seed registers through stores
        put(0, 4'd5, 4'd1, 0, 0, 32'hFFFF_FFFF, 2'd0);
        put(1, 4'd5, 4'd2, 0, 0, 32'h1, 2'd1);
        put(2, 4'd5, 4'd3, 0, 0, 32'h7, 2'd2);
        put(3, 4'd5, 4'd4, 0, 0, 32'h1234_5678, 2'd3);
        step();
        idle_all();
        put(0, 4'd5, 4'd10, 0, 0, 32'd31, 2'd2);
        step();

        // R4 overflow by one, R4 sum of all ones, R5 equal, R5 underflow by one
        idle_all();
        put(0, 4'd1, 4'd5, 4'd1, 4'd2, 0, 2'd0);
        put(1, 4'd1, 4'd6, 4'd1, 4'd0, 0, 2'd1);
        put(2, 4'd2, 4'd7, 4'd2, 4'd2, 0, 2'd2);
        put(3, 4'd2, 4'd8, 4'd0, 4'd2, 0, 2'd3);
        step();
        chk("R4", {resp_w[0], data_w[0], tago_w[0]}, {2'b10, 32'h0, 2'd0});
        chk("R4", {resp_w[1], data_w[1], tago_w[1]}, {2'b01, 32'hFFFF_FFFF, 2'd1});
        chk("R5", {resp_w[3], data_w[3], tago_w[3]}, {2'b10, 32'h0, 2'd3});

        // R6 shift by 0 and 31; R3 fetch of untouched overflow target
        idle_all();
        put(0, 4'd3, 4'd9, 4'd4, 4'd0, 0, 2'd1);
        put(1, 4'd4, 4'd11, 4'd4, 4'd10, 0, 2'd0);
        put(2, 4'd4, 4'd12, 4'd1, 4'd10, 0, 2'd3);
        put(3, 4'd6, 0, 4'd5, 0, 0, 2'd2);
        step();
        chk("R6", {resp_w[0], data_w[0], tago_w[0]}, {2'b01, 32'h1234_5678, 2'd1});
        chk("R6", {resp_w[2], data_w[2], tago_w[2]}, {2'b01, 32'h1, 2'd3});

        // R8: taken branch, idle gap, store cancelled, then fetch shows no write
        idle_all();
        put(0, 4'd7, 0, 4'd0, 0, 0, 2'd0);
        step();
        idle_all();
        step();
        put(0, 4'd5, 4'd13, 0, 0, 32'hAAAA_5555, 2'd1);
        put(1, 4'd5, 4'd14, 0, 0, 32'h55, 2'd2);
        step();
        chk("R8", {resp_w[0], data_w[0], tago_w[0]}, {2'b11, 32'h0, 2'd1});
        idle_all();
        put(0, 4'd6, 0, 4'd13, 0, 0, 2'd3);
        step();
        chk("R8", {resp_w[0], data_w[0], tago_w[0]}, {2'b01, 32'h0, 2'd3});

        // R8: cancelled branch does not arm a second skip
        idle_all();
        put(1, 4'd8, 0, 4'd1, 4'd1, 0, 2'd0);
        step();
        put(1, 4'd7, 0, 4'd0, 0, 0, 2'd1);
        step();
        put(1, 4'd5, 4'd15, 0, 0, 32'hBEEF, 2'd2);
        step();
        chk("R8", {resp_w[1], data_w[1], tago_w[1]}, {2'b01, 32'h0, 2'd2});

        // R9: two ports write one register, a third reads it the same cycle
        idle_all();
        put(0, 4'd6, 0, 4'd14, 0, 0, 2'd0);
        put(1, 4'd5, 4'd14, 0, 0, 32'h1111, 2'd1);
        put(2, 4'd5, 4'd14, 0, 0, 32'h2222, 2'd2);
        step();
        chk("R9", {resp_w[0], data_w[0], tago_w[0]}, {2'b01, 32'h55, 2'd0});
        idle_all();
        put(3, 4'd6, 0, 4'd14, 0, 0, 2'd3);
        step();
        chk("R9", {resp_w[3], data_w[3], tago_w[3]}, {2'b01, 32'h1111, 2'd3});

        // R11: illegal code leaves its destination untouched
        idle_all();
        put(3, 4'd12, 4'd15, 4'd1, 4'd1, 32'h9, 2'd1);
        step();
        put(3, 4'd6, 0, 4'd15, 0, 0, 2'd0);
        step();
        chk("R11", {resp_w[3], data_w[3], tago_w[3]}, {2'b01, 32'hBEEF, 2'd0});

        // Constrained random traffic, unique tags per cycle (R12)
        for (int i = 0; i < 3000; i++) begin
            int rot;
            rot = $urandom_range(0, 3);
            for (int p = 0; p < NP; p++) begin
                int c;
                c = $urandom_range(0, 20);
                if (c > 11) c = (c > 15) ? 5 : c - 5;
                put(p, 4'(c), 4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
                    4'($urandom_range(0, 15)), pick_val(), 2'((p + rot) % NP));
            end
            step();
        end
        idle_all();
        step();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule